// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. Pages are 1 KB. Bits 31:20 of the virtual address index a first-level table of up to 4096 entries. Bits 19:10 index a second-level table of 1024 entries. Bits 9:0 pass through unchanged as the byte offset.

The walker has three interfaces. The first takes translation requests with a valid/ready handshake. The second reads memory: it issues a request with its own handshake and then waits for a single response word. The third returns a one-cycle result that carries either the physical address or a fault code.

The first-level table base and its entry count come from two register inputs. Both are sampled when a request is accepted. Only one walk is in flight at a time.

Table entries are 32 bits wide:

- Bits 31:10 hold a 1 KB-aligned base. This is a table base at the first level and a frame base at the second level.
- Bit 0 is the valid flag.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: After a request is accepted with an in-range first-level index, the first memory read goes to `tbl_base + 4*vaddr[31:20]`, using the `tbl_base` value sampled at acceptance.
- R3: If the first-level entry has bit 0 set, the second read goes to `{entry[31:10], 10'b0} + 4*vaddr[19:10]`.
- R4: If the second-level entry has bit 0 set, the result has `done_fault` = 0 and `done_paddr` = `{entry[31:10], vaddr[9:0]}`. The walk makes exactly two memory reads.
- R5: If `{1'b0, vaddr[31:20]} >= tbl_len` at acceptance, no memory read is issued. `done_valid` rises in the next cycle with `done_fault` = 1.
- R6: If the first-level entry has bit 0 clear, no second read is made. The result follows the response by one cycle with `done_fault` = 2.
- R7: If the second-level entry has bit 0 clear, the result has `done_fault` = 3.
- R8: Whenever `done_fault` is nonzero, `done_paddr` is 0.
- R9: `req_ready` is low from the cycle after acceptance until the walk returns to idle. While it is low, `req_valid` and all request fields are ignored.
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until the cycle in which `mem_req_ready` is high.
- R11: `done_valid` is high for exactly one cycle. It comes the cycle after the last memory response, and `req_ready` returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Byte address of first-level table |
| tbl_len | input | 13 | Number of legal first-level entries (0 to 4096) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_fault | output | 2 | 0 ok, 1 length, 2 first-level invalid, 3 second-level invalid |

## Verification
A corrupted walk state shows up at the ports within one cycle. It appears as a memory request at the wrong time, as `req_ready` out of step, or as a read address that does not match the table arithmetic. A wrongly latched offset or table base shows only at the next read or at the result, so the comparison is made every cycle rather than only at results. Memory stalls and response latency are varied, and base and length change between walks. This exposes any value that is used live instead of being captured at acceptance.

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int L2_W    = 10,
  parameter int ENTRY_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [ENTRY_W-1:0]       tbl_base,
  input  logic [VA_W-OFF_W-L2_W:0] tbl_len,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [ENTRY_W-1:0]       mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [ENTRY_W-1:0]       mem_rsp_data,
  output logic                     done_valid,
  output logic [ENTRY_W-1:0]       done_paddr,
  output logic [1:0]               done_fault
);
  localparam int L1_W    = VA_W - OFF_W - L2_W;
  localparam int LO_W    = OFF_W + L2_W;
  localparam int FRAME_W = ENTRY_W - OFF_W;

  localparam logic [1:0] F_NONE  = 2'd0;
  localparam logic [1:0] F_LEN   = 2'd1;
  localparam logic [1:0] F_OUTER = 2'd2;
  localparam logic [1:0] F_INNER = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WAIT1, S_RD2, S_WAIT2, S_DONE} st_t;

  st_t                st;
  logic [LO_W-1:0]    va_lo;
  logic [ENTRY_W-1:0] addr_q;
  logic [ENTRY_W-1:0] paddr_q;
  logic [1:0]         fault_q;

  wire [L1_W-1:0]    outer_idx = req_vaddr[VA_W-1:LO_W];
  wire               len_bad   = {1'b0, outer_idx} >= tbl_len;
  wire               accept    = req_valid && req_ready;
  wire [FRAME_W-1:0] rsp_frame = mem_rsp_data[ENTRY_W-1:OFF_W];
  wire               rsp_ok    = mem_rsp_data[0];

  logic unused_entry_bits;
  assign unused_entry_bits = &{1'b0, mem_rsp_data[OFF_W-1:1]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD1) || (st == S_RD2);
  assign mem_req_addr  = addr_q;
  assign done_valid    = (st == S_DONE);
  assign done_paddr    = paddr_q;
  assign done_fault    = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_lo   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= F_NONE;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          va_lo   <= req_vaddr[LO_W-1:0];
          paddr_q <= '0;
          if (len_bad) begin
            fault_q <= F_LEN;
            st      <= S_DONE;
          end else begin
            fault_q <= F_NONE;
            addr_q  <= tbl_base + ENTRY_W'({outer_idx, 2'b00});
            st      <= S_RD1;
          end
        end
        S_RD1: if (mem_req_ready) st <= S_WAIT1;
        S_WAIT1: if (mem_rsp_valid) begin
          if (!rsp_ok) begin
            fault_q <= F_OUTER;
            st      <= S_DONE;
          end else begin
            addr_q <= {rsp_frame, {OFF_W{1'b0}}} + ENTRY_W'({va_lo[LO_W-1:OFF_W], 2'b00});
            st     <= S_RD2;
          end
        end
        S_RD2: if (mem_req_ready) st <= S_WAIT2;
        S_WAIT2: if (mem_rsp_valid) begin
          if (!rsp_ok) fault_q <= F_INNER;
          else         paddr_q <= {rsp_frame, va_lo[OFF_W-1:0]};
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LEN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && len_bad) |=> (done_valid && done_fault == F_LEN && !mem_req_valid)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault != F_NONE) |-> (done_paddr == '0)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R9
  AST_OUTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT1 && mem_rsp_valid && !rsp_ok) |=> (done_valid && done_fault == F_OUTER)); // R6
  AST_INNER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT2 && mem_rsp_valid && rsp_ok) |=>
      (done_valid && done_fault == F_NONE && done_paddr[OFF_W-1:0] == $past(va_lo[OFF_W-1:0]))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready)); // R11
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, tbl_base;
  logic [12:0] tbl_len;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic [1:0]  done_fault;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .tbl_base(tbl_base), .tbl_len(tbl_len),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] pmem [int unsigned];
  logic [31:0] jv[$];
  logic [31:0] jb[$];
  logic [12:0] jl[$];

  int          ph;
  int          lat;
  logic [31:0] m_addr, m_va, m_paddr;
  logic [1:0]  m_fault;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int o, input int i, input int f);
    logic [11:0] ob = o[11:0];
    logic [9:0]  ib = i[9:0];
    logic [9:0]  fb = f[9:0];
    return {ob, ib, fb};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic job(input logic [31:0] v, input logic [31:0] b, input logic [12:0] l);
    jv.push_back(v); jb.push_back(b); jl.push_back(l);
  endtask

  task automatic compare_all();
    string ftag;
    chk(req_ready == (ph == 0), "R9", "req_ready", {31'b0, req_ready}, {31'b0, ph == 0});
    chk(mem_req_valid == (ph == 1 || ph == 3), "R10", "mem_req_valid",
        {31'b0, mem_req_valid}, {31'b0, ph == 1 || ph == 3});
    if (ph == 1) chk(mem_req_addr == m_addr, "R2", "first read addr", mem_req_addr, m_addr);
    if (ph == 3) chk(mem_req_addr == m_addr, "R3", "second read addr", mem_req_addr, m_addr);
    chk(done_valid == (ph == 5), "R11", "done_valid", {31'b0, done_valid}, {31'b0, ph == 5});
    if (ph == 5) begin
      case (m_fault)
        2'd1: ftag = "R5";
        2'd2: ftag = "R6";
        2'd3: ftag = "R7";
        default: ftag = "R4";
      endcase
      chk(done_fault == m_fault, ftag, "done_fault", {30'b0, done_fault}, {30'b0, m_fault});
      chk(done_paddr == m_paddr, (m_fault == 0) ? "R4" : "R8", "done_paddr", done_paddr, m_paddr);
    end
  endtask

  task automatic drive_and_step();
    logic [31:0] d;
    logic [11:0] o;
    req_valid     = (jv.size() > 0) && ($urandom % 4 != 0);
    req_vaddr     = (jv.size() > 0) ? jv[0] : $urandom;
    tbl_base      = (jb.size() > 0) ? jb[0] : $urandom;
    tbl_len       = (jl.size() > 0) ? jl[0] : 13'd0;
    mem_req_ready = ($urandom % 3 != 0);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
    if (ph == 2 || ph == 4) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(m_addr);
      end else lat--;
    end
    d = mem_rsp_data;
    case (ph)
      0: if (req_valid) begin
        o = req_vaddr[31:20];
        m_va = req_vaddr;
        m_paddr = 32'h0;
        void'(jv.pop_front()); void'(jb.pop_front()); void'(jl.pop_front());
        if ({1'b0, o} >= tbl_len) begin
          m_fault = 2'd1; ph = 5;
        end else begin
          m_fault = 2'd0; m_addr = tbl_base + 32'(o) * 4; ph = 1;
        end
      end
      1, 3: if (mem_req_ready) begin ph = ph + 1; lat = $urandom % 3; end
      2: if (mem_rsp_valid) begin
        if (!d[0]) begin m_fault = 2'd2; ph = 5; end
        else begin m_addr = {d[31:10], 10'b0} + 32'(m_va[19:10]) * 4; ph = 3; end
      end
      4: if (mem_rsp_valid) begin
        if (!d[0]) m_fault = 2'd3;
        else m_paddr = {d[31:10], m_va[9:0]};
        ph = 5;
      end
      5: ph = 0;
      default: ph = 0;
    endcase
  endtask

  initial begin
    int cyc;
    int idle;
    logic [31:0] ba, bb;
    ba = 32'h0001_0000;
    bb = 32'h0100_0000;
    pmem[ba + 0*4]      = 32'h0002_0001;
    pmem[ba + 1*4]      = 32'h0003_0401;
    pmem[ba + 3*4]      = 32'h0004_0000;
    pmem[ba + 7*4]      = 32'h0005_0001;
    pmem[bb + 4095*4]   = 32'h0002_0001;
    pmem[32'h20000 + 0*4]    = 32'h1234_5401;
    pmem[32'h20000 + 5*4]    = 32'hABCD_E001;
    pmem[32'h20000 + 1023*4] = 32'hFFFF_FC01;
    pmem[32'h20000 + 2*4]    = 32'h7777_7000;
    pmem[32'h30400 + 9*4]    = 32'h0000_0401;
    pmem[32'h50000 + 1*4]    = 32'h8000_0001;

    job(va(0, 0, 10'h3FF), ba, 13'd8);
    job(va(0, 5, 10'h155), ba, 13'd8);
    job(va(0, 1023, 0), ba, 13'd8);
    job(va(0, 2, 7), ba, 13'd8);
    job(va(0, 3, 1), ba, 13'd8);
    job(va(1, 9, 10'h200), ba, 13'd8);
    job(va(3, 0, 0), ba, 13'd8);
    job(va(2, 0, 0), ba, 13'd8);
    job(va(7, 1, 10'h03A), ba, 13'd8);
    job(va(8, 0, 0), ba, 13'd8);
    job(va(4095, 5, 1), ba, 13'd8);
    job(va(4095, 5, 1), bb, 13'd4096);
    job(va(0, 0, 0), ba, 13'd0);
    for (int k = 0; k < 6; k++) job(va(0, k % 2 == 0 ? 0 : 5, k * 37), ba, 13'd8);

    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; tbl_base = '0; tbl_len = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    ph = 0; lat = 0; m_addr = '0; m_va = '0; m_paddr = '0; m_fault = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'b0, req_ready}, 32'd1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", {31'b0, mem_req_valid}, 32'd0);
    chk(done_valid == 1'b0, "R1", "done_valid in reset", {31'b0, done_valid}, 32'd0);
    rst_n = 1'b1;
    drive_and_step();

    cyc = 0; idle = 0;
    while (idle < 5) begin
      @(negedge clk);
      compare_all();
      drive_and_step();
      if (jv.size() == 0 && ph == 0) idle++;
      cyc++;
      if (cyc > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 watchdog expired actual=%0d expected=<20000", cyc);
        break;
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule